// File: doc/BRIEF.md
# Per-Virtual-Link Ingress Frame Policer

This block sits at one ingress port of a frame switch and decides, frame by frame, whether each arriving frame is forwarded or discarded. A frame-start event carries the 16-bit link identifier field of the destination MAC address (its two least significant bytes) together with the frame length. The low bits of that field select one of `NUM_LINKS` table entries. Each entry holds the link's minimum spacing between frames (the bandwidth allocation gap, in time units), its largest permitted frame length and an enable bit. Each link keeps its own timestamp of the last frame it accepted. A frame is forwarded only when enough time has passed since that timestamp, less a global jitter allowance. Because every link is judged only against its own history, an end system that floods one link cannot steal bandwidth from links that keep to their contract.

Every decision appears two cycles after the frame-start event, as a one-cycle strobe with the forward/drop bit and the link index. Dropped frames on configured links increment a saturating per-link counter. Frames that map to no configured link increment a separate unknown-link counter. A simple register port loads table entries and the jitter allowance, and a read port returns any counter one cycle after the request. A free-running timebase divides the clock by `TICK_DIV` to form the policing time unit.

Top module: `vl_policer`

## Requirements
- R1: The link index is `fs_dmac_lo[IDX_W-1:0]`. A frame is unknown when `fs_dmac_lo[15:IDX_W]` is nonzero or the indexed entry is disabled. An unknown frame is dropped and counted in the unknown-link counter, which is read at any `rd_addr` whose top bit is 1.
- R2: For a frame-start sampled at clock edge k, `dec_valid` is high for exactly the cycle after edge k+1, with `dec_link` equal to the link index. No strobe occurs without a frame-start.
- R3: The first frame on a link after that link's entry is written is forwarded, provided it is known and not oversize.
- R4: Let `bag` be the link's gap and `jit` the jitter allowance. A known, correctly sized frame on a link with a previous acceptance is forwarded when the elapsed time units since that acceptance are at least `bag - jit`, or always when `jit >= bag`. Otherwise it is dropped. Only forwarded frames move the link's timestamp.
- R5: A frame whose length exceeds the link's maximum length is dropped and counted on its link. It does not move the link's timestamp.
- R6: Frames and drops on one link have no effect on the forward/drop outcome or the drop counter of any other link.
- R7: A written gap of 0 is stored as 1, and a written gap above 128 is stored as 128.
- R8: Each drop counter and the unknown-link counter saturates at 2^CNT_W-1.
- R9: Writing a link's table entry clears that link's drop counter and its acceptance history.
- R10: A link that has been idle for longer than the timestamp range still has its next frame forwarded.
- R11: After reset, `dec_valid` and `rd_valid` are low, all counters read zero, all links are disabled and the jitter allowance is zero.
- R12: A read request with `rd_en` high at edge k gives `rd_valid` high and the counter value in the cycle after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_valid | input | 1 | Frame-start event strobe |
| fs_dmac_lo | input | 16 | Link identifier field of the destination MAC |
| fs_len | input | LEN_W | Frame length in bytes |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_link | input | IDX_W | Table entry index |
| cfg_en | input | 1 | Entry enable (link known) |
| cfg_bag | input | 8 | Minimum frame spacing in time units |
| cfg_maxlen | input | LEN_W | Largest permitted frame length |
| jit_we | input | 1 | Jitter allowance write strobe |
| jit_val | input | 8 | Jitter allowance in time units |
| rd_en | input | 1 | Counter read request |
| rd_addr | input | IDX_W+1 | Counter address; top bit selects the unknown-link counter |
| dec_valid | output | 1 | Decision strobe |
| dec_fwd | output | 1 | 1 = forward, 0 = drop |
| dec_link | output | IDX_W | Link index of the decided frame |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | CNT_W | Counter value |

## Verification
The bench builds the policer with four links, a 9-bit timestamp, one time unit per clock and 4-bit counters. With these values every link can be swept over several gap and jitter combinations at every spacing from back-to-back to one past the gap. The counters reach saturation after fifteen drops, and a 600-cycle idle period crosses the timestamp wrap. A cycle-exact reference in the bench predicts each strobe and each counter value from the issue cycles alone.

// File: rtl/vl_policer_pkg.sv
package vl_policer_pkg;

  localparam int BAG_W   = 8;
  localparam int BAG_MAX = 128;

  typedef enum logic [1:0] {
    VD_PASS     = 2'd0,
    VD_RATE     = 2'd1,
    VD_OVERSIZE = 2'd2,
    VD_UNKNOWN  = 2'd3
  } verdict_e;

  // keep the stored gap in 1..BAG_MAX
  function automatic logic [BAG_W-1:0] clamp_bag(input logic [BAG_W-1:0] b);
    if (b == '0)
      return BAG_W'(1);
    else if (b > BAG_W'(BAG_MAX))
      return BAG_W'(BAG_MAX);
    else
      return b;
  endfunction

  // acceptance threshold after jitter allowance, floored at zero
  function automatic logic [BAG_W-1:0] gap_threshold(input logic [BAG_W-1:0] bag,
                                                     input logic [BAG_W-1:0] jit);
    if (bag > jit)
      return bag - jit;
    else
      return '0;
  endfunction

endpackage

// File: rtl/vl_timebase.sv
module vl_timebase #(
  parameter int TS_W     = 16,
  parameter int TICK_DIV = 100
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] now
);

  generate
    if (TICK_DIV <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) now <= '0;
        else     now <= now + 1'b1;
      end
    end else begin : g_prescale
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pre_q <= '0;
          now   <= '0;
        end else if (pre_q == PW'(TICK_DIV - 1)) begin
          pre_q <= '0;
          now   <= now + 1'b1;
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/vl_key_extract.sv
module vl_key_extract #(
  parameter int IDX_W = 4,
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs_valid,
  input  logic [15:0]      fs_dmac_lo,
  input  logic [LEN_W-1:0] fs_len,
  output logic             s1_valid,
  output logic [IDX_W-1:0] s1_idx,
  output logic             s1_outrange,
  output logic [LEN_W-1:0] s1_len
);

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= fs_valid;
  end

  always_ff @(posedge clk) begin
    s1_idx      <= fs_dmac_lo[IDX_W-1:0];
    s1_outrange <= (fs_dmac_lo[15:IDX_W] != '0);
    s1_len      <= fs_len;
  end

endmodule

// File: rtl/vl_rate_table.sv
module vl_rate_table
  import vl_policer_pkg::*;
#(
  parameter int NUM_LINKS = 16,
  parameter int IDX_W     = 4,
  parameter int TS_W      = 16,
  parameter int LEN_W     = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  now,
  input  logic             s1_valid,
  input  logic [IDX_W-1:0] s1_idx,
  input  logic             s1_outrange,
  input  logic [LEN_W-1:0] s1_len,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_link,
  input  logic             cfg_en,
  input  logic [BAG_W-1:0] cfg_bag,
  input  logic [LEN_W-1:0] cfg_maxlen,
  input  logic             jit_we,
  input  logic [BAG_W-1:0] jit_val,
  output logic             dec_valid,
  output logic             dec_fwd,
  output logic [IDX_W-1:0] dec_link,
  output verdict_e         dec_verdict
);

  logic [NUM_LINKS-1:0] en_q;
  logic [NUM_LINKS-1:0] primed_q;
  logic [BAG_W-1:0]     bag_q    [NUM_LINKS];
  logic [LEN_W-1:0]     maxlen_q [NUM_LINKS];
  logic [TS_W-1:0]      last_q   [NUM_LINKS];
  logic [BAG_W-1:0]     jit_q;
  logic [IDX_W-1:0]     scrub_ptr;

  logic [TS_W-1:0]  elapsed;
  logic [BAG_W-1:0] thr;
  verdict_e         verdict;
  logic [TS_W-1:0]  scrub_age;
  logic             scrub_stale;
  logic             accept;

  // decision for the frame held in stage 1
  always_comb begin
    elapsed = now - last_q[s1_idx];
    thr     = gap_threshold(bag_q[s1_idx], jit_q);
    if (s1_outrange || !en_q[s1_idx])
      verdict = VD_UNKNOWN;
    else if (s1_len > maxlen_q[s1_idx])
      verdict = VD_OVERSIZE;
    else if (primed_q[s1_idx] && (elapsed < TS_W'(thr)))
      verdict = VD_RATE;
    else
      verdict = VD_PASS;
  end

  assign accept = s1_valid && (verdict == VD_PASS);

  // background sweep: forget histories older than any legal gap
  assign scrub_age   = now - last_q[scrub_ptr];
  assign scrub_stale = primed_q[scrub_ptr] && (scrub_age > TS_W'(BAG_MAX));

  always_ff @(posedge clk) begin
    if (rst) scrub_ptr <= '0;
    else     scrub_ptr <= scrub_ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid   <= 1'b0;
      dec_fwd     <= 1'b0;
      dec_link    <= '0;
      dec_verdict <= VD_PASS;
    end else begin
      dec_valid   <= s1_valid;
      dec_fwd     <= accept;
      dec_link    <= s1_idx;
      dec_verdict <= verdict;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      primed_q <= '0;
    end else begin
      if (scrub_stale) primed_q[scrub_ptr] <= 1'b0;
      if (accept)      primed_q[s1_idx]    <= 1'b1;
      if (cfg_we)      primed_q[cfg_link]  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) last_q[s1_idx] <= now;
  end

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (cfg_we) en_q[cfg_link] <= cfg_en;
  end

  always_ff @(posedge clk) begin
    if (cfg_we) begin
      bag_q[cfg_link]    <= clamp_bag(cfg_bag);
      maxlen_q[cfg_link] <= cfg_maxlen;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         jit_q <= '0;
    else if (jit_we) jit_q <= jit_val;
  end

endmodule

// File: rtl/vl_drop_counters.sv
module vl_drop_counters #(
  parameter int NUM_LINKS = 16,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_drop,
  input  logic             ev_unknown,
  input  logic [IDX_W-1:0] ev_link,
  input  logic             clr_we,
  input  logic [IDX_W-1:0] clr_link,
  input  logic             rd_en,
  input  logic [IDX_W:0]   rd_addr,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);

  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q [NUM_LINKS];
  logic [CNT_W-1:0] unk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LINKS; i++) cnt_q[i] <= '0;
    end else begin
      if (ev_drop && !ev_unknown && (cnt_q[ev_link] != CNT_TOP))
        cnt_q[ev_link] <= cnt_q[ev_link] + 1'b1;
      if (clr_we)
        cnt_q[clr_link] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      unk_q <= '0;
    else if (ev_drop && ev_unknown && (unk_q != CNT_TOP))
      unk_q <= unk_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_valid <= 1'b0;
    else     rd_valid <= rd_en;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= rd_addr[IDX_W] ? unk_q : cnt_q[rd_addr[IDX_W-1:0]];
  end

endmodule

// File: rtl/vl_policer.sv
module vl_policer
  import vl_policer_pkg::*;
#(
  parameter int NUM_LINKS = 16,
  parameter int TS_W      = 16,
  parameter int TICK_DIV  = 100,
  parameter int LEN_W     = 11,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = $clog2(NUM_LINKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fs_valid,
  input  logic [15:0]      fs_dmac_lo,
  input  logic [LEN_W-1:0] fs_len,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_link,
  input  logic             cfg_en,
  input  logic [BAG_W-1:0] cfg_bag,
  input  logic [LEN_W-1:0] cfg_maxlen,
  input  logic             jit_we,
  input  logic [BAG_W-1:0] jit_val,
  input  logic             rd_en,
  input  logic [IDX_W:0]   rd_addr,
  output logic             dec_valid,
  output logic             dec_fwd,
  output logic [IDX_W-1:0] dec_link,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data
);

  logic [TS_W-1:0]  now;
  logic             s1_valid;
  logic [IDX_W-1:0] s1_idx;
  logic             s1_outrange;
  logic [LEN_W-1:0] s1_len;
  verdict_e         dec_verdict;

  vl_timebase #(.TS_W(TS_W), .TICK_DIV(TICK_DIV)) u_time (
    .clk (clk),
    .rst (rst),
    .now (now)
  );

  vl_key_extract #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_key (
    .clk         (clk),
    .rst         (rst),
    .fs_valid    (fs_valid),
    .fs_dmac_lo  (fs_dmac_lo),
    .fs_len      (fs_len),
    .s1_valid    (s1_valid),
    .s1_idx      (s1_idx),
    .s1_outrange (s1_outrange),
    .s1_len      (s1_len)
  );

  vl_rate_table #(
    .NUM_LINKS(NUM_LINKS), .IDX_W(IDX_W), .TS_W(TS_W), .LEN_W(LEN_W)
  ) u_table (
    .clk         (clk),
    .rst         (rst),
    .now         (now),
    .s1_valid    (s1_valid),
    .s1_idx      (s1_idx),
    .s1_outrange (s1_outrange),
    .s1_len      (s1_len),
    .cfg_we      (cfg_we),
    .cfg_link    (cfg_link),
    .cfg_en      (cfg_en),
    .cfg_bag     (cfg_bag),
    .cfg_maxlen  (cfg_maxlen),
    .jit_we      (jit_we),
    .jit_val     (jit_val),
    .dec_valid   (dec_valid),
    .dec_fwd     (dec_fwd),
    .dec_link    (dec_link),
    .dec_verdict (dec_verdict)
  );

  vl_drop_counters #(
    .NUM_LINKS(NUM_LINKS), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .ev_drop    (dec_valid && !dec_fwd),
    .ev_unknown (dec_verdict == VD_UNKNOWN),
    .ev_link    (dec_link),
    .clr_we     (cfg_we),
    .clr_link   (cfg_link),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

endmodule

// File: rtl/vl_policer_chk.sv
module vl_policer_chk #(
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fs_valid,
  input logic [15-IDX_W:0] id_hi,
  input logic              dec_valid,
  input logic              dec_fwd,
  input logic              rd_en,
  input logic              rd_valid
);

  logic [1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst)              age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2
  dec_follows_fs_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2 && $past(fs_valid, 2)) |-> dec_valid);

  // R2
  dec_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (age_q >= 2'd2 && $past(fs_valid, 2)));

  // R1
  unknown_prefix_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2 && dec_valid && $past(id_hi != '0, 2)) |-> !dec_fwd);

  // R11
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!dec_valid && !rd_valid));

  // R12
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q >= 2'd2) |-> (rd_valid == $past(rd_en)));

endmodule

bind vl_policer vl_policer_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .fs_valid  (fs_valid),
  .id_hi     (fs_dmac_lo[15:IDX_W]),
  .dec_valid (dec_valid),
  .dec_fwd   (dec_fwd),
  .rd_en     (rd_en),
  .rd_valid  (rd_valid)
);

// File: tb/vl_policer_tb.sv
`timescale 1ns/1ps
module vl_policer_tb;

  localparam int NL = 4;
  localparam int IW = 2;
  localparam int TSW = 9;
  localparam int LW = 11;
  localparam int CW = 4;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fs_valid = 1'b0;
  logic [15:0] fs_dmac_lo = '0;
  logic [LW-1:0] fs_len = '0;
  logic cfg_we = 1'b0;
  logic [IW-1:0] cfg_link = '0;
  logic cfg_en = 1'b0;
  logic [7:0] cfg_bag = '0;
  logic [LW-1:0] cfg_maxlen = '0;
  logic jit_we = 1'b0;
  logic [7:0] jit_val = '0;
  logic rd_en = 1'b0;
  logic [IW:0] rd_addr = '0;
  logic dec_valid, dec_fwd, rd_valid;
  logic [IW-1:0] dec_link;
  logic [CW-1:0] rd_data;

  always #2.5 clk = ~clk;

  vl_policer #(.NUM_LINKS(NL), .TS_W(TSW), .TICK_DIV(1), .LEN_W(LW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .fs_valid(fs_valid), .fs_dmac_lo(fs_dmac_lo), .fs_len(fs_len),
    .cfg_we(cfg_we), .cfg_link(cfg_link), .cfg_en(cfg_en), .cfg_bag(cfg_bag),
    .cfg_maxlen(cfg_maxlen), .jit_we(jit_we), .jit_val(jit_val), .rd_en(rd_en),
    .rd_addr(rd_addr), .dec_valid(dec_valid), .dec_fwd(dec_fwd), .dec_link(dec_link),
    .rd_valid(rd_valid), .rd_data(rd_data));

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 1'b0;

  // reference model state
  int m_en[NL], m_bag[NL], m_max[NL], m_primed[NL], m_last[NL], m_cnt[NL];
  int m_unk = 0;
  int m_jit = 0;

  // expected decision queue
  int q_link[256], q_fwd[256], q_cyc[256];
  string q_req[256];
  int wp = 0, rp = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // decision monitor
  always @(negedge clk) begin
    if (dec_valid) begin
      if (rp == wp) begin
        check("R2 unexpected strobe", 1, 0);
      end else begin
        check({q_req[rp % 256], " strobe cycle"}, cyc, q_cyc[rp % 256]);
        check({q_req[rp % 256], " link"}, int'(dec_link), q_link[rp % 256]);
        check({q_req[rp % 256], " forward"}, int'(dec_fwd), q_fwd[rp % 256]);
        rp++;
      end
    end else if (rp != wp && cyc > q_cyc[rp % 256]) begin
      check("R2 missing strobe", 0, 1);
      rp++;
    end
  end

  function automatic int sat(input int v);
    return (v < CMAX) ? v + 1 : CMAX;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input string req, input logic [15:0] id, input int len = 64);
    int issue, idx, thr, fwd;
    issue = cyc + 1;
    idx = int'(id[IW-1:0]);
    if (id[15:IW] != '0 || m_en[idx] == 0) begin
      fwd = 0; m_unk = sat(m_unk);
    end else if (len > m_max[idx]) begin
      fwd = 0; m_cnt[idx] = sat(m_cnt[idx]);
    end else begin
      thr = (m_bag[idx] > m_jit) ? m_bag[idx] - m_jit : 0;
      if (m_primed[idx] == 0 || issue - m_last[idx] >= thr) begin
        fwd = 1; m_primed[idx] = 1; m_last[idx] = issue;
      end else begin
        fwd = 0; m_cnt[idx] = sat(m_cnt[idx]);
      end
    end
    q_link[wp % 256] = idx; q_fwd[wp % 256] = fwd;
    q_cyc[wp % 256] = issue + 1; q_req[wp % 256] = req; wp++;
    fs_valid = 1'b1; fs_dmac_lo = id; fs_len = LW'(len);
    @(negedge clk);
    fs_valid = 1'b0;
  endtask

  task automatic cfg(input int link, input int en, input int bag, input int maxlen);
    cfg_we = 1'b1; cfg_link = IW'(link); cfg_en = en[0];
    cfg_bag = 8'(bag); cfg_maxlen = LW'(maxlen);
    @(negedge clk);
    cfg_we = 1'b0;
    m_en[link] = en; m_max[link] = maxlen;
    m_bag[link] = (bag == 0) ? 1 : (bag > 128 ? 128 : bag);   // R7 clamp
    m_primed[link] = 0; m_cnt[link] = 0;
    idle(2);
  endtask

  task automatic set_jit(input int j);
    jit_we = 1'b1; jit_val = 8'(j);
    @(negedge clk);
    jit_we = 1'b0; m_jit = j;
  endtask

  task automatic chk_cnt(input string req, input int addr);
    idle(3);
    rd_en = 1'b1; rd_addr = (IW+1)'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    check("R12 read strobe", int'(rd_valid), 1);
    check(req, int'(rd_data), (addr >= NL) ? m_unk : m_cnt[addr]);
  endtask

  initial begin
    int bags[5] = '{1, 2, 3, 5, 8};
    int jits[3] = '{0, 1, 3};
    for (int i = 0; i < NL; i++) begin
      m_en[i] = 0; m_bag[i] = 1; m_max[i] = 0; m_primed[i] = 0; m_last[i] = 0; m_cnt[i] = 0;
    end
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 dec_valid after reset", int'(dec_valid), 0);
    check("R11 rd_valid after reset", int'(rd_valid), 0);
    for (int a = 0; a <= NL; a++) chk_cnt("R11 counter zero after reset", a);
    send("R11 link disabled after reset", 16'h0000);
    chk_cnt("R1 unknown counter", NL);

    // R3 R4 R9 sweep over links, gaps and jitter
    for (int l = 0; l < NL; l++) begin
      for (int b = 0; b < 5; b++) begin
        for (int j = 0; j < 3; j++) begin
          set_jit(jits[j]);
          cfg(l, 1, bags[b], 100);
          chk_cnt("R9 counter cleared by entry write", l);
          send("R3 first frame after write", 16'(l));
          for (int g = 1; g <= bags[b] + 1; g++) begin
            idle(g - 1);
            send("R4 gap rule", 16'(l));
          end
          chk_cnt("R4 drop count", l);
        end
      end
    end

    // R6 flooding on link 0 while link 1 keeps its contract
    set_jit(0);
    cfg(0, 1, 8, 100);
    cfg(1, 1, 4, 100);
    for (int i = 0; i < 24; i++) send("R6 interleaved", (i % 4 == 0) ? 16'h0001 : 16'h0000);
    chk_cnt("R6 compliant link counter", 1);
    check("R6 compliant link had no drops", m_cnt[1], 0);
    chk_cnt("R6 flooding link counter", 0);

    // R8 saturation
    cfg(2, 1, 128, 100);
    for (int i = 0; i < 20; i++) send("R8 burst", 16'h0002);
    chk_cnt("R8 saturated counter", 2);
    check("R8 reference saturated", m_cnt[2], CMAX);

    // R7 clamping
    cfg(3, 1, 0, 100);
    send("R7 gap 0 stored as 1", 16'h0003);
    send("R7 gap 0 stored as 1", 16'h0003);
    cfg(3, 1, 200, 100);
    send("R7 gap 200 stored as 128", 16'h0003);
    idle(126);
    send("R7 gap 127 dropped", 16'h0003);
    send("R7 gap 128 forwarded", 16'h0003);

    // R5 oversize
    cfg(1, 1, 4, 100);
    send("R5 length at limit", 16'h0001, 100);
    idle(1);
    send("R5 oversize dropped", 16'h0001, 101);
    idle(1);
    send("R5 oversize left timestamp", 16'h0001, 100);
    chk_cnt("R5 oversize counted", 1);

    // R10 idle across timestamp wrap (600 mod 512 = 88 < 128)
    cfg(0, 1, 128, 100);
    send("R10 before idle", 16'h0000);
    idle(599);
    send("R10 after long idle", 16'h0000);

    // R1 unknown links
    send("R1 nonzero high id bits", 16'h0104);
    send("R1 nonzero high id bits", 16'h8001);
    cfg(2, 0, 4, 100);
    send("R1 disabled entry", 16'h0002);
    chk_cnt("R1 unknown counter", NL);
    chk_cnt("R1 unknown counter alias", NL + 3);

    idle(4);
    check("R2 all decisions seen", rp, wp);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule